// File: doc/BRIEF.md
# Banked Memory Address Translator

This block sits between a CPU with a 16-bit address bus and a memory system with a 24-bit physical address space. For every access it decides which on-chip resource the address falls into and produces the physical address that goes to memory. The regions are:

- an I/O register block,
- a nonvolatile memory area,
- internal RAM,
- a paged window,
- external RAM.

When regions overlap, a fixed priority picks the winner. An access that hits no region raises a fault strobe.

A configuration byte relocates the I/O block and the internal RAM. Each one is placed on a 4 KB boundary chosen by one nibble of that byte. A page number, together with a window made of start, end, shift and virtual offset, redirects the CPU addresses inside the window into paged memory. All other addresses pass through unchanged, zero-extended. The window parameters are loaded through a small register-write port. The result of each access is registered and appears one clock after the access is presented.

Top module: `bank_xlat`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `res_valid`, `res_region`, `res_fault` and `res_paddr` are all zero. The window registers reset to start = end = 0, which is an empty window, with shift 0 and offset 0.
- R2: An access sampled with `acc_valid` high on a rising edge is reported on the outputs from that edge until the next one. After an edge with `acc_valid` low, `res_valid`, `res_region` and `res_fault` are zero.
- R3: An address hits the I/O block when `acc_addr[15:12]` equals `map_cfg[3:0]` and `acc_addr[11:0]` is below the I/O span. The span is 64 when `LARGE_IO`=0 and 1024 when `LARGE_IO`=1.
- R4: An address hits internal RAM when `acc_addr[15:12]` equals `map_cfg[7:4]` and `acc_addr[11:0]` is below `RAM_SPAN`, which defaults to 256.
- R5: An address hits nonvolatile memory when it lies in `NVM_BASE` up to, but not including, `NVM_BASE+NVM_SPAN`. By default this is 0xB600 to 0xB7FF.
- R6: When window start <= address < window end, `res_paddr` = ((address - start) + (`page_num` << shift) + offset) mod 2^24. If no higher region hits, the region reported is the window.
- R7: An address outside the window gives `res_paddr` = {8'h00, address}.
- R8: `res_region` is one-hot: bit 0 is I/O, bit 1 is nonvolatile memory, bit 2 is internal RAM, bit 3 is the window and bit 4 is external RAM. The priority, from highest to lowest, is I/O, nonvolatile memory, internal RAM, window, external RAM.
- R9: An address hits external RAM when it is below `EXT_TOP`, which defaults to 0x8000.
- R10: A valid access that hits no region sets `res_fault` for that one result cycle, with `res_region` zero. `res_fault` is never high without `res_valid`.
- R11: When `win_wr_en` is high on a rising edge, `win_wr_sel` picks the window register that is loaded:
  - 0 loads start from `win_wr_data[15:0]`,
  - 1 loads end from `win_wr_data[15:0]`,
  - 2 loads shift from `win_wr_data[3:0]`,
  - 3 loads offset from `win_wr_data[23:0]`.

  An access sampled on the same edge still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 16 | CPU address |
| map_cfg | input | 8 | Low nibble is the I/O base, high nibble is the RAM base |
| page_num | input | PAGE_W (8) | Current page number |
| win_wr_en | input | 1 | Window register write enable |
| win_wr_sel | input | 2 | Window register select |
| win_wr_data | input | 24 | Window register write data |
| res_valid | output | 1 | Result valid |
| res_region | output | 5 | One-hot selected region |
| res_paddr | output | 24 | Translated physical address |
| res_fault | output | 1 | One-cycle strobe for an access that hits no region |

## Verification
Every result of this block (region, physical address and fault) is due exactly one rising edge after the access is presented. A window write lands on its own edge, so it first affects an access presented on the following edge. The bench therefore drives an access and waits one edge. It samples 1 ns after that edge, before the next access can change anything, and compares against values computed from the requirements. One check drives a window write and an access on the same edge to confirm that the old window value is used. Back-to-back accesses run one per cycle, which allows a full sweep of all 65,536 addresses plus dense sweeps of the overlap and wrap cases.

// File: rtl/bx_pkg.sv
package bx_pkg;
  localparam int ADDR_W = 16;
  localparam int PHYS_W = 24;
  localparam int SHIFT_W = 4;
  localparam int REG_N = 5;

  // Region bit positions, in priority order (lower index wins).
  localparam int RG_IO   = 0;
  localparam int RG_NVM  = 1;
  localparam int RG_IRAM = 2;
  localparam int RG_WIN  = 3;
  localparam int RG_EXT  = 4;

  typedef enum logic [1:0] {
    WSEL_START = 2'd0,
    WSEL_STOP  = 2'd1,
    WSEL_SHIFT = 2'd2,
    WSEL_VOFF  = 2'd3
  } wsel_e;

  typedef struct packed {
    logic [ADDR_W-1:0]  start;
    logic [ADDR_W-1:0]  stop;
    logic [SHIFT_W-1:0] shift;
    logic [PHYS_W-1:0]  voff;
  } win_cfg_t;
endpackage

// File: rtl/bx_window_regs.sv
module bx_window_regs
  import bx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [PHYS_W-1:0] wr_data,
  output win_cfg_t          cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (wr_en) begin
      case (wsel_e'(wr_sel))
        WSEL_START: cfg.start <= wr_data[ADDR_W-1:0];
        WSEL_STOP:  cfg.stop  <= wr_data[ADDR_W-1:0];
        WSEL_SHIFT: cfg.shift <= wr_data[SHIFT_W-1:0];
        default:    cfg.voff  <= wr_data;
      endcase
    end
  end

  assert_shift_load_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd2) |=> cfg.shift == $past(wr_data[SHIFT_W-1:0]));
  assert_start_load_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd0) |=> cfg.start == $past(wr_data[ADDR_W-1:0]));
endmodule

// File: rtl/bx_page_xlat.sv
module bx_page_xlat
  import bx_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] page,
  input  win_cfg_t          cfg,
  output logic              hit,
  output logic [PHYS_W-1:0] xaddr
);
  logic [ADDR_W-1:0] offs;
  logic [PHYS_W-1:0] page_base;

  always_comb begin
    hit       = (addr >= cfg.start) && (addr < cfg.stop);
    offs      = addr - cfg.start;
    page_base = PHYS_W'(page) << cfg.shift;
    if (hit) xaddr = PHYS_W'(offs) + page_base + cfg.voff;
    else     xaddr = PHYS_W'(addr);
  end
endmodule

// File: rtl/bx_region_dec.sv
module bx_region_dec
  import bx_pkg::*;
#(
  parameter int IO_SPAN  = 64,
  parameter int RAM_SPAN = 256,
  parameter int NVM_BASE = 'hB600,
  parameter int NVM_SPAN = 512,
  parameter int EXT_TOP  = 'h8000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        cfg,
  input  logic              win_hit,
  output logic [REG_N-1:0]  raw_hit,
  output logic [REG_N-1:0]  sel
);
  localparam int LOW_W = ADDR_W - 4;
  localparam logic [LOW_W:0]  IO_LIM  = (LOW_W+1)'(IO_SPAN);
  localparam logic [LOW_W:0]  RAM_LIM = (LOW_W+1)'(RAM_SPAN);
  localparam logic [ADDR_W:0] NVM_LO  = (ADDR_W+1)'(NVM_BASE);
  localparam logic [ADDR_W:0] NVM_HI  = (ADDR_W+1)'(NVM_BASE + NVM_SPAN);
  localparam logic [ADDR_W:0] EXT_LIM = (ADDR_W+1)'(EXT_TOP);

  logic [LOW_W:0]  low;
  logic [ADDR_W:0] wide;

  always_comb begin
    low  = {1'b0, addr[LOW_W-1:0]};
    wide = {1'b0, addr};
    raw_hit          = '0;
    raw_hit[RG_IO]   = (addr[ADDR_W-1:LOW_W] == cfg[3:0]) && (low < IO_LIM);
    raw_hit[RG_NVM]  = (wide >= NVM_LO) && (wide < NVM_HI);
    raw_hit[RG_IRAM] = (addr[ADDR_W-1:LOW_W] == cfg[7:4]) && (low < RAM_LIM);
    raw_hit[RG_WIN]  = win_hit;
    raw_hit[RG_EXT]  = wide < EXT_LIM;
  end

  // Fixed priority: a region wins only if no lower-indexed region hit.
  logic [REG_N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar g = 0; g < REG_N; g++) begin : g_prio
    assign sel[g]    = raw_hit[g] & ~seen[g];
    assign seen[g+1] = seen[g] | raw_hit[g];
  end
endmodule

// File: rtl/bank_xlat.sv
module bank_xlat
  import bx_pkg::*;
#(
  parameter int LARGE_IO = 0,
  parameter int RAM_SPAN = 256,
  parameter int NVM_BASE = 'hB600,
  parameter int NVM_SPAN = 512,
  parameter int EXT_TOP  = 'h8000,
  parameter int PAGE_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [15:0]       acc_addr,
  input  logic [7:0]        map_cfg,
  input  logic [PAGE_W-1:0] page_num,
  input  logic              win_wr_en,
  input  logic [1:0]        win_wr_sel,
  input  logic [23:0]       win_wr_data,
  output logic              res_valid,
  output logic [4:0]        res_region,
  output logic [23:0]       res_paddr,
  output logic              res_fault
);
  localparam int IO_SPAN = (LARGE_IO != 0) ? 1024 : 64;

  win_cfg_t          win_cfg;
  logic              win_hit;
  logic [PHYS_W-1:0] xaddr;
  logic [REG_N-1:0]  raw_hit;
  logic [REG_N-1:0]  sel;

  bx_window_regs u_wregs (
    .clk(clk), .rst(rst), .wr_en(win_wr_en), .wr_sel(win_wr_sel),
    .wr_data(win_wr_data), .cfg(win_cfg)
  );

  bx_page_xlat #(.PAGE_W(PAGE_W)) u_xlat (
    .addr(acc_addr), .page(page_num), .cfg(win_cfg),
    .hit(win_hit), .xaddr(xaddr)
  );

  bx_region_dec #(
    .IO_SPAN(IO_SPAN), .RAM_SPAN(RAM_SPAN), .NVM_BASE(NVM_BASE),
    .NVM_SPAN(NVM_SPAN), .EXT_TOP(EXT_TOP)
  ) u_dec (
    .addr(acc_addr), .cfg(map_cfg), .win_hit(win_hit),
    .raw_hit(raw_hit), .sel(sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_region <= '0;
      res_paddr  <= '0;
      res_fault  <= 1'b0;
    end else begin
      res_valid  <= acc_valid;
      res_region <= acc_valid ? sel : '0;
      res_paddr  <= acc_valid ? xaddr : res_paddr;
      res_fault  <= acc_valid && (sel == '0);
    end
  end

  assert_fault_alone_R10: assert property (@(posedge clk) disable iff (rst)
    res_fault |-> (res_valid && res_region == '0));
  assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(res_region));
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!res_valid && res_region == '0 && !res_fault));
  assert_io_first_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && raw_hit[RG_IO]) |=> res_region == 5'b00001);
  assert_passthru_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !win_hit) |=> res_paddr == {8'h00, $past(acc_addr)});
endmodule

// File: tb/test_bank_xlat.sv
`timescale 1ns/1ps
module test_bank_xlat;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [7:0] map_cfg = '0;
  logic [7:0] page_num = '0;
  logic win_wr_en = 1'b0;
  logic [1:0] win_wr_sel = '0;
  logic [23:0] win_wr_data = '0;
  logic res_valid, res_fault, lg_valid, lg_fault;
  logic [4:0] res_region, lg_region;
  logic [23:0] res_paddr, lg_paddr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] sh_start = '0;
  logic [15:0] sh_stop = '0;
  logic [3:0]  sh_shift = '0;
  logic [23:0] sh_voff = '0;

  always #2.5 clk = ~clk;

  bank_xlat i_bank_xlat (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .map_cfg(map_cfg), .page_num(page_num), .win_wr_en(win_wr_en),
    .win_wr_sel(win_wr_sel), .win_wr_data(win_wr_data),
    .res_valid(res_valid), .res_region(res_region), .res_paddr(res_paddr),
    .res_fault(res_fault)
  );

  bank_xlat #(.LARGE_IO(1)) i_bank_xlat_lg (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .map_cfg(map_cfg), .page_num(page_num), .win_wr_en(win_wr_en),
    .win_wr_sel(win_wr_sel), .win_wr_data(win_wr_data),
    .res_valid(lg_valid), .res_region(lg_region), .res_paddr(lg_paddr),
    .res_fault(lg_fault)
  );

  function automatic logic in_win(input logic [15:0] a);
    return (a >= sh_start) && (a < sh_stop);
  endfunction

  // Region codes: bit0 IO, bit1 NVM, bit2 IRAM, bit3 window, bit4 EXT (R8).
  function automatic logic [4:0] model_region(input logic [15:0] a,
      input logic [7:0] c, input int io_span, input logic w);
    int off;
    off = int'(a[11:0]);
    if (a[15:12] == c[3:0] && off < io_span) return 5'b00001;
    if (int'(a) >= 'hB600 && int'(a) < 'hB800) return 5'b00010;
    if (a[15:12] == c[7:4] && off < 256) return 5'b00100;
    if (w) return 5'b01000;
    if (int'(a) < 'h8000) return 5'b10000;
    return 5'b00000;
  endfunction

  function automatic logic [23:0] model_paddr(input logic [15:0] a,
      input logic [7:0] p);
    longint v;
    if (!in_win(a)) return {8'h00, a};
    v = longint'(a) - longint'(sh_start) + (longint'(p) << sh_shift)
        + longint'(sh_voff);
    return v[23:0];
  endfunction

  function automatic string tag_of(input logic [4:0] r);
    case (r)
      5'b00001: return "R3 R8";
      5'b00010: return "R5 R8";
      5'b00100: return "R4 R8";
      5'b01000: return "R6 R8";
      5'b10000: return "R9 R7";
      default:  return "R10";
    endcase
  endfunction

  task automatic fail_line(input string tag, input string what,
      input logic [31:0] act, input logic [31:0] exp);
    failures++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  task automatic compare(input logic [15:0] a, input logic [4:0] er,
      input logic [4:0] elr, input logic [23:0] ep);
    string t;
    bit bad;
    t = tag_of(er);
    bad = 1'b0;
    checks++;
    if (res_valid !== 1'b1) begin bad = 1; fail_line("R2", "valid", 32'(res_valid), 1); end
    if (res_region !== er) begin bad = 1; fail_line(t, $sformatf("region@%h", a), 32'(res_region), 32'(er)); end
    if (res_fault !== (er == 5'b0)) begin bad = 1; fail_line("R10", $sformatf("fault@%h", a), 32'(res_fault), 32'(er == 5'b0)); end
    if (res_paddr !== ep) begin bad = 1; fail_line(in_win(a) ? "R6" : "R7", $sformatf("paddr@%h", a), 32'(res_paddr), 32'(ep)); end
    if (lg_region !== elr) begin bad = 1; fail_line("R3 large", $sformatf("region@%h", a), 32'(lg_region), 32'(elr)); end
    if (bad) $display("  (context: addr=%h cfg=%h page=%h)", a, map_cfg, page_num);
  endtask

  task automatic drive(input logic [15:0] a);
    logic [4:0] er, elr;
    logic [23:0] ep;
    er  = model_region(a, map_cfg, 64, in_win(a));
    elr = model_region(a, map_cfg, 1024, in_win(a));
    ep  = model_paddr(a, page_num);
    acc_valid = 1'b1;
    acc_addr  = a;
    @(posedge clk);
    #1;
    acc_valid = 1'b0;
    compare(a, er, elr, ep);
  endtask

  task automatic shadow_write(input logic [1:0] s, input logic [23:0] d);
    case (s)
      2'd0: sh_start = d[15:0];
      2'd1: sh_stop  = d[15:0];
      2'd2: sh_shift = d[3:0];
      default: sh_voff = d;
    endcase
  endtask

  task automatic wr_win(input logic [1:0] s, input logic [23:0] d);
    win_wr_en = 1'b1; win_wr_sel = s; win_wr_data = d;
    @(posedge clk);
    #1;
    win_wr_en = 1'b0;
    shadow_write(s, d);
  endtask

  task automatic set_win(input logic [15:0] st, input logic [15:0] sp,
      input logic [3:0] sh, input logic [23:0] vo);
    wr_win(2'd0, {8'h00, st});
    wr_win(2'd1, {8'h00, sp});
    wr_win(2'd2, {20'h0, sh});
    wr_win(2'd3, vo);
  endtask

  // R11: window write and access on the same edge; access sees the old value.
  task automatic drive_wr(input logic [15:0] a, input logic [1:0] s,
      input logic [23:0] d);
    logic [4:0] er, elr;
    logic [23:0] ep;
    er  = model_region(a, map_cfg, 64, in_win(a));
    elr = model_region(a, map_cfg, 1024, in_win(a));
    ep  = model_paddr(a, page_num);
    acc_valid = 1'b1; acc_addr = a;
    win_wr_en = 1'b1; win_wr_sel = s; win_wr_data = d;
    @(posedge clk);
    #1;
    acc_valid = 1'b0; win_wr_en = 1'b0;
    shadow_write(s, d);
    compare(a, er, elr, ep);
  endtask

  task automatic check_quiet(input string tag);
    checks++;
    if (res_valid !== 1'b0 || res_region !== 5'b0 || res_fault !== 1'b0 ||
        (tag == "R1" && res_paddr !== 24'h0)) begin
      failures++;
      $display("FAIL %s quiet outputs actual=%b/%b/%b/%h expected=0/00000/0/000000",
               tag, res_valid, res_region, res_fault, res_paddr);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_quiet("R1");
    rst = 1'b0;
    @(posedge clk);
    #1;
    check_quiet("R1");

    // R1: window empty after reset, so everything passes through.
    map_cfg = 8'h1F;
    drive(16'h4000);
    drive(16'h0000);

    // R2: idle cycle after an access.
    @(posedge clk);
    #1;
    check_quiet("R2");

    // Full sweep: IO at 0xF000, RAM at 0x1000, window 0x4000..0xBFFF.
    page_num = 8'h5A;
    set_win(16'h4000, 16'hC000, 4'd14, 24'h100000);
    for (int i = 0; i < 65536; i++) drive(16'(i));

    // R11: same-edge write uses old start, later access uses new one.
    drive_wr(16'h4000, 2'd0, 24'h004001);
    drive(16'h4000);
    drive(16'h4001);

    // Overlap of IO and RAM on one nibble, window wraps at 2^24.
    map_cfg = 8'hBB;
    page_num = 8'hFF;
    set_win(16'hB000, 16'hB100, 4'd15, 24'hFFFFFF);
    for (int i = 'hA000; i < 'hC000; i++) drive(16'(i));

    // IO and RAM both at zero, above external RAM.
    map_cfg = 8'h00;
    page_num = 8'h00;
    set_win(16'h9000, 16'h9000, 4'd0, 24'h0);
    for (int i = 0; i < 'h2000; i++) drive(16'(i));
    for (int i = 0; i < 65536; i += 61) drive(16'(i));

    // R6: single-address window boundaries.
    set_win(16'h9000, 16'h9001, 4'd3, 24'h000010);
    page_num = 8'h07;
    drive(16'h8FFF);
    drive(16'h9000);
    drive(16'h9001);

    // R6: every shift amount.
    map_cfg = 8'hEE;
    page_num = 8'hA5;
    set_win(16'h2000, 16'h3000, 4'd0, 24'h000123);
    for (int s = 0; s < 16; s++) begin
      wr_win(2'd2, 24'(s));
      drive(16'h2345);
      drive(16'h2FFF);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule